// File: doc/BRIEF.md
# Boundary-Scan Control for a Bidirectional Two-Port Transceiver

This block holds the boundary-scan cells and the pin muxing for a transceiver with an A port and a B port. Each port is split into groups. Each group has its own A-to-B enable, which is active high, and its own B-to-A enable, which is active low. The block sits between the package pins and the transceiver core. In normal mode the pins and the core are joined straight through. In test mode the pins are driven from the scan cells. In modified test mode every pin driver is turned off.

Each scan cell has two stages. The first is a capture/shift flop that forms a serial chain from scan input to scan output. The second is an update latch that feeds the pins in test mode. The update latches change only on an update strobe, so the pins hold their values while new data is shifted. Four dedicated direction cells sit at the top of the chain and set the direction of each group in test mode. During capture, each data cell picks its source according to the current drive direction of its pin.

Instruction decode and the TAP state machine sit outside this block. They present the strobes, a boundary-register select bit and a two-bit mode code. A clamp operation is the test mode combined with the boundary register deselected.

Top module: `bidir_scan_ctl`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), every chain flop is 0 and scan_out is 0. Every update latch is also 0, except the B-to-A direction latches, which reset to 1. In test mode this leaves all pin enables off and the data outputs at 0.
- R2: While bsr_sel and shift_dr are high and capture_dr is low, each clock edge moves the chain up by one: bit 0 takes scan_in, and bit i takes the old bit i-1. scan_out always shows bit N-1.
- R3: The update latches load the whole chain only on an edge where bsr_sel and update_dr are both high. While shifting, the test-mode pin outputs and enables do not change.
- R4: In normal mode (mode code 0, and the unused code 3), the pin outputs and pin enables follow the core outputs and core enables. The core receives the data pins and both enable pins unchanged. The update latches have no effect.
- R5: In test mode (mode code 1), the A pins are driven by update latches 0 to W-1, and the B pins by latches W to 2W-1, with bit j of a port taken from latch j of that port's range.
- R6: In test mode, the B pins of group g are enabled when the A-to-B latch at position 2W+2g holds 1. The A pins of group g are enabled when the B-to-A latch at position 2W+2g+1 holds 0. Otherwise the pins act as inputs.
- R7: In test and modified test modes, the data pins pass through to the core. The core's enable inputs are held inactive: A-to-B at 0 and B-to-A at 1.
- R8: In modified test mode (mode code 2), every A and B pin enable is 0, whatever the latch contents.
- R9: On a capture in normal mode, a data cell of group g loads the core output if its port is driven in that group, and the pin input otherwise. The direction cells load the A-to-B and B-to-A enable pins.
- R10: On a capture in test or modified test mode, every data cell loads its pin input.
- R11: With bsr_sel low, the capture, shift and update strobes have no effect on the chain, the latches or scan_out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bsr_sel | input | 1 | Boundary register selected in scan path |
| capture_dr | input | 1 | Capture strobe |
| shift_dr | input | 1 | Shift strobe |
| update_dr | input | 1 | Update strobe |
| mode | input | 2 | 0 normal, 1 test, 2 modified test, 3 normal |
| scan_in | input | 1 | Serial input to chain bit 0 |
| scan_out | output | 1 | Serial output from chain bit N-1 |
| a_pin_in | input | W | A port pin receive values |
| a_pin_out | output | W | A port pin drive values |
| a_pin_oe | output | NGRP | A port driver enable per group |
| b_pin_in | input | W | B port pin receive values |
| b_pin_out | output | W | B port pin drive values |
| b_pin_oe | output | NGRP | B port driver enable per group |
| en_a2b_pin | input | NGRP | A-to-B enable pins, active high |
| en_b2a_n_pin | input | NGRP | B-to-A enable pins, active low |
| core_a_out | input | W | Core data toward A pins |
| core_b_out | input | W | Core data toward B pins |
| core_a_oe | input | NGRP | Core request to drive A per group |
| core_b_oe | input | NGRP | Core request to drive B per group |
| core_a_in | output | W | A pin data to core |
| core_b_in | output | W | B pin data to core |
| core_en_a2b | output | NGRP | A-to-B enable to core |
| core_en_b2a_n | output | NGRP | B-to-A enable to core |

## Verification
All sixteen combinations of the four direction cells are loaded in test mode, each with different A and B data. This shows whether each enable reads the right chain position with the right polarity, and whether the two data ranges come out swapped. Capture is run with the per-group drive pattern set to each of its two values, and with core and pin data that differ in every bit. This separates "core source" from "pin source" for each group, and it is repeated in test mode to show the pin-only rule. A walking serial pattern checks the shift order. Pin stability is checked on every shift cycle. Shift and update runs with bsr_sel low show that the chain and the latches ignore the strobes.

// File: rtl/bidir_scan_pkg.sv
// Shared mode encoding for the bidirectional boundary-scan control.
// Assumes the instruction decoder outside presents one of these codes.
package bidir_scan_pkg;
    typedef enum logic [1:0] {
        MODE_NORMAL = 2'b00,
        MODE_TEST   = 2'b01,
        MODE_HIGHZ  = 2'b10,
        MODE_SPARE  = 2'b11
    } scan_mode_e;
endpackage

// File: rtl/bsr_chain.sv
// Capture/shift chain with a separate update latch per cell.
// Assumes N >= 2; capture wins over shift when both strobes are high.
module bsr_chain #(
    parameter int          N       = 20,
    parameter logic [N-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sel,
    input  logic         capture,
    input  logic         shift,
    input  logic         update,
    input  logic         scan_in,
    input  logic [N-1:0] cap_data,
    output logic         scan_out,
    output logic [N-1:0] upd_q
);
    logic [N-1:0] chain_q;

    // Chain flops: capture parallel data or shift one place toward bit N-1.
    always_ff @(posedge clk) begin
        if (!rst_n)
            chain_q <= '0;
        else if (sel && capture)
            chain_q <= cap_data;
        else if (sel && shift)
            chain_q <= {chain_q[N-2:0], scan_in};
    end

    // Update latches: copy the chain only on a selected update strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)
            upd_q <= RST_VAL;
        else if (sel && update)
            upd_q <= chain_q;
    end

    assign scan_out = chain_q[N-1];

    assert_shift_move_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && shift && !capture) |=> (scan_out == $past(chain_q[N-2]) && chain_q[0] == $past(scan_in)));

    assert_latch_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(sel && update) |=> $stable(upd_q));

    assert_deselect_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !sel |=> $stable(chain_q));
endmodule

// File: rtl/bsr_dir.sv
// Per-group drive-enable selection for both ports.
// Assumes the B-to-A direction latch is active low, the A-to-B one active high.
module bsr_dir #(
    parameter int NGRP = 2
) (
    input  logic            test_mode,
    input  logic            hiz_mode,
    input  logic [NGRP-1:0] cell_a2b,
    input  logic [NGRP-1:0] cell_b2a,
    input  logic [NGRP-1:0] core_a_oe,
    input  logic [NGRP-1:0] core_b_oe,
    output logic [NGRP-1:0] a_drv,
    output logic [NGRP-1:0] b_drv
);
    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        // Enable choice for group g: off, from latches, or from the core.
        always_comb begin
            if (hiz_mode) begin
                a_drv[g] = 1'b0;
                b_drv[g] = 1'b0;
            end else if (test_mode) begin
                a_drv[g] = ~cell_b2a[g];
                b_drv[g] = cell_a2b[g];
            end else begin
                a_drv[g] = core_a_oe[g];
                b_drv[g] = core_b_oe[g];
            end
        end
    end
endmodule

// File: rtl/bsr_pinmux.sv
// Data muxing between pins, core and scan cells, plus capture source choice.
// Assumes W = NGRP * GW with bit i belonging to group i / GW.
module bsr_pinmux #(
    parameter int NGRP = 2,
    parameter int GW   = 4,
    localparam int W   = NGRP * GW
) (
    input  logic            norm_mode,
    input  logic [W-1:0]    upd_a,
    input  logic [W-1:0]    upd_b,
    input  logic [W-1:0]    core_a_out,
    input  logic [W-1:0]    core_b_out,
    input  logic [W-1:0]    a_pin_in,
    input  logic [W-1:0]    b_pin_in,
    input  logic [NGRP-1:0] a_drv,
    input  logic [NGRP-1:0] b_drv,
    input  logic [NGRP-1:0] en_a2b_pin,
    input  logic [NGRP-1:0] en_b2a_n_pin,
    output logic [W-1:0]    a_pin_out,
    output logic [W-1:0]    b_pin_out,
    output logic [W-1:0]    core_a_in,
    output logic [W-1:0]    core_b_in,
    output logic [NGRP-1:0] core_en_a2b,
    output logic [NGRP-1:0] core_en_b2a_n,
    output logic [W-1:0]    cap_a,
    output logic [W-1:0]    cap_b
);
    // Pin drive data: core in normal mode, update latches otherwise.
    always_comb begin
        a_pin_out = norm_mode ? core_a_out : upd_a;
        b_pin_out = norm_mode ? core_b_out : upd_b;
    end

    // Core side: data always passes, enables are held inactive outside normal mode.
    always_comb begin
        core_a_in     = a_pin_in;
        core_b_in     = b_pin_in;
        core_en_a2b   = norm_mode ? en_a2b_pin   : '0;
        core_en_b2a_n = norm_mode ? en_b2a_n_pin : '1;
    end

    for (genvar i = 0; i < W; i++) begin : g_bit
        localparam int G = i / GW;
        // Capture source for bit i: core data when this side drives in normal mode.
        always_comb begin
            cap_a[i] = (norm_mode && a_drv[G]) ? core_a_out[i] : a_pin_in[i];
            cap_b[i] = (norm_mode && b_drv[G]) ? core_b_out[i] : b_pin_in[i];
        end
    end
endmodule

// File: rtl/bidir_scan_ctl.sv
// Boundary-scan control for a grouped two-port bidirectional transceiver.
// Chain layout: A data at 0..W-1, B data at W..2W-1, then per group g the
// A-to-B direction cell at 2W+2g and the B-to-A direction cell at 2W+2g+1.
// Assumes strobes are one-cycle enables on clk from an external TAP.
module bidir_scan_ctl
    import bidir_scan_pkg::*;
#(
    parameter int NGRP = 2,
    parameter int GW   = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bsr_sel,
    input  logic                 capture_dr,
    input  logic                 shift_dr,
    input  logic                 update_dr,
    input  logic [1:0]           mode,
    input  logic                 scan_in,
    output logic                 scan_out,
    input  logic [NGRP*GW-1:0]   a_pin_in,
    output logic [NGRP*GW-1:0]   a_pin_out,
    output logic [NGRP-1:0]      a_pin_oe,
    input  logic [NGRP*GW-1:0]   b_pin_in,
    output logic [NGRP*GW-1:0]   b_pin_out,
    output logic [NGRP-1:0]      b_pin_oe,
    input  logic [NGRP-1:0]      en_a2b_pin,
    input  logic [NGRP-1:0]      en_b2a_n_pin,
    input  logic [NGRP*GW-1:0]   core_a_out,
    input  logic [NGRP*GW-1:0]   core_b_out,
    input  logic [NGRP-1:0]      core_a_oe,
    input  logic [NGRP-1:0]      core_b_oe,
    output logic [NGRP*GW-1:0]   core_a_in,
    output logic [NGRP*GW-1:0]   core_b_in,
    output logic [NGRP-1:0]      core_en_a2b,
    output logic [NGRP-1:0]      core_en_b2a_n
);
    localparam int W    = NGRP * GW;
    localparam int DIRB = 2 * W;
    localparam int N    = DIRB + 2 * NGRP;

    // Reset image of the update latches: B-to-A cells inactive (1).
    function automatic logic [N-1:0] reset_image();
        logic [N-1:0] v;
        v = '0;
        for (int g = 0; g < NGRP; g++) v[DIRB + 2*g + 1] = 1'b1;
        return v;
    endfunction
    localparam logic [N-1:0] RST_IMG = reset_image();

    scan_mode_e     mode_e;
    logic           test_mode, hiz_mode, norm_mode;
    logic [N-1:0]   cap_vec, upd_vec;
    logic [W-1:0]   cap_a, cap_b;
    logic [NGRP-1:0] cell_a2b, cell_b2a, a_drv, b_drv;

    // Mode decode; the spare code behaves as normal.
    always_comb begin
        mode_e    = scan_mode_e'(mode);
        test_mode = (mode_e == MODE_TEST);
        hiz_mode  = (mode_e == MODE_HIGHZ);
        norm_mode = !test_mode && !hiz_mode;
    end

    assign cap_vec[W-1:0]    = cap_a;
    assign cap_vec[DIRB-1:W] = cap_b;
    for (genvar g = 0; g < NGRP; g++) begin : g_dircell
        assign cap_vec[DIRB + 2*g]     = en_a2b_pin[g];
        assign cap_vec[DIRB + 2*g + 1] = en_b2a_n_pin[g];
        assign cell_a2b[g] = upd_vec[DIRB + 2*g];
        assign cell_b2a[g] = upd_vec[DIRB + 2*g + 1];
    end

    bsr_chain #(.N(N), .RST_VAL(RST_IMG)) chain_i (
        .clk(clk), .rst_n(rst_n), .sel(bsr_sel), .capture(capture_dr),
        .shift(shift_dr), .update(update_dr), .scan_in(scan_in),
        .cap_data(cap_vec), .scan_out(scan_out), .upd_q(upd_vec)
    );

    bsr_dir #(.NGRP(NGRP)) dir_i (
        .test_mode(test_mode), .hiz_mode(hiz_mode),
        .cell_a2b(cell_a2b), .cell_b2a(cell_b2a),
        .core_a_oe(core_a_oe), .core_b_oe(core_b_oe),
        .a_drv(a_drv), .b_drv(b_drv)
    );

    bsr_pinmux #(.NGRP(NGRP), .GW(GW)) mux_i (
        .norm_mode(norm_mode),
        .upd_a(upd_vec[W-1:0]), .upd_b(upd_vec[DIRB-1:W]),
        .core_a_out(core_a_out), .core_b_out(core_b_out),
        .a_pin_in(a_pin_in), .b_pin_in(b_pin_in),
        .a_drv(a_drv), .b_drv(b_drv),
        .en_a2b_pin(en_a2b_pin), .en_b2a_n_pin(en_b2a_n_pin),
        .a_pin_out(a_pin_out), .b_pin_out(b_pin_out),
        .core_a_in(core_a_in), .core_b_in(core_b_in),
        .core_en_a2b(core_en_a2b), .core_en_b2a_n(core_en_b2a_n),
        .cap_a(cap_a), .cap_b(cap_b)
    );

    assign a_pin_oe = a_drv;
    assign b_pin_oe = b_drv;

    assert_highz_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b10) |-> (a_pin_oe == '0 && b_pin_oe == '0));

    assert_core_en_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b01 || mode == 2'b10) |-> (core_en_a2b == '0 && core_en_b2a_n == '1));

    assert_pins_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b01 && $past(mode) == 2'b01 && !$past(bsr_sel && update_dr))
        |-> ($stable(a_pin_out) && $stable(b_pin_out) && $stable(a_pin_oe) && $stable(b_pin_oe)));
endmodule

// File: tb/bidir_scan_ctl_tb_top.sv
module bidir_scan_ctl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NGRP = 2;
    localparam int GW   = 2;
    localparam int W    = NGRP * GW;
    localparam int DIRB = 2 * W;
    localparam int N    = DIRB + 2 * NGRP;

    logic clk = 1'b0;
    logic rst_n, bsr_sel, capture_dr, shift_dr, update_dr, scan_in, scan_out;
    logic [1:0] mode;
    logic [W-1:0] a_pin_in, a_pin_out, b_pin_in, b_pin_out;
    logic [W-1:0] core_a_out, core_b_out, core_a_in, core_b_in;
    logic [NGRP-1:0] a_pin_oe, b_pin_oe, en_a2b_pin, en_b2a_n_pin;
    logic [NGRP-1:0] core_a_oe, core_b_oe, core_en_a2b, core_en_b2a_n;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [N-1:0] cur_lat;

    always #(CLK_PERIOD/2) clk = ~clk;

    bidir_scan_ctl #(.NGRP(NGRP), .GW(GW)) dut_i (
        .clk(clk), .rst_n(rst_n), .bsr_sel(bsr_sel), .capture_dr(capture_dr),
        .shift_dr(shift_dr), .update_dr(update_dr), .mode(mode),
        .scan_in(scan_in), .scan_out(scan_out),
        .a_pin_in(a_pin_in), .a_pin_out(a_pin_out), .a_pin_oe(a_pin_oe),
        .b_pin_in(b_pin_in), .b_pin_out(b_pin_out), .b_pin_oe(b_pin_oe),
        .en_a2b_pin(en_a2b_pin), .en_b2a_n_pin(en_b2a_n_pin),
        .core_a_out(core_a_out), .core_b_out(core_b_out),
        .core_a_oe(core_a_oe), .core_b_oe(core_b_oe),
        .core_a_in(core_a_in), .core_b_in(core_b_in),
        .core_en_a2b(core_en_a2b), .core_en_b2a_n(core_en_b2a_n)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    // Test-mode pins expected from a latch image.
    task automatic check_test_pins(input string req, input logic [N-1:0] img);
        logic [NGRP-1:0] ea, eb;
        for (int g = 0; g < NGRP; g++) begin
            eb[g] = img[DIRB + 2*g];
            ea[g] = ~img[DIRB + 2*g + 1];
        end
        check({req, " a_out"}, 32'(a_pin_out), 32'(img[W-1:0]));
        check({req, " b_out"}, 32'(b_pin_out), 32'(img[DIRB-1:W]));
        check({req, " a_oe"},  32'(a_pin_oe),  32'(ea));
        check({req, " b_oe"},  32'(b_pin_oe),  32'(eb));
    endtask

    // Shift a full image in (bit N-1 first), checking pins hold, then update.
    task automatic load_vec(input logic [N-1:0] v, input bit chk_hold);
        shift_dr = 1'b1;
        for (int i = N - 1; i >= 0; i--) begin
            scan_in = v[i];
            step();
            if (chk_hold) check_test_pins("R3 hold during shift", cur_lat);
        end
        shift_dr = 1'b0;
        update_dr = 1'b1;
        step();
        update_dr = 1'b0;
        cur_lat = v;
    endtask

    // Capture then shift the chain out, top bit first.
    task automatic readout(output logic [N-1:0] got);
        capture_dr = 1'b1;
        step();
        capture_dr = 1'b0;
        shift_dr = 1'b1;
        scan_in = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            got[i] = scan_out;
            step();
        end
        shift_dr = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [N-1:0] v, got, exp;
        rst_n = 1'b0; bsr_sel = 1'b1; capture_dr = 1'b0; shift_dr = 1'b0;
        update_dr = 1'b0; scan_in = 1'b0; mode = 2'b01;
        a_pin_in = '0; b_pin_in = '0; en_a2b_pin = '0; en_b2a_n_pin = '1;
        core_a_out = '0; core_b_out = '0; core_a_oe = '0; core_b_oe = '0;
        repeat (3) step();
        rst_n = 1'b1;
        step();

        // R1: reset image
        cur_lat = '0;
        for (int g = 0; g < NGRP; g++) cur_lat[DIRB + 2*g + 1] = 1'b1;
        check("R1 scan_out", 32'(scan_out), 32'd0);
        check_test_pins("R1 reset pins", cur_lat);

        // R5 R6 R3: all direction-cell combinations in test mode
        for (int k = 0; k < 16; k++) begin
            v = '0;
            v[W-1:0]    = W'((k * 5 + 3) % 16);
            v[DIRB-1:W] = W'((k * 11 + 6) % 16);
            for (int g = 0; g < NGRP; g++) begin
                v[DIRB + 2*g]     = k[2*g];
                v[DIRB + 2*g + 1] = k[2*g + 1];
            end
            load_vec(v, 1'b1);
            check_test_pins("R5 R6 test drive", cur_lat);
        end

        // R8: modified test turns all drivers off; R7 core enables inactive
        mode = 2'b10; a_pin_in = 4'h9; b_pin_in = 4'h6;
        en_a2b_pin = 2'b11; en_b2a_n_pin = 2'b00;
        #1;
        check("R8 a_oe", 32'(a_pin_oe), 32'd0);
        check("R8 b_oe", 32'(b_pin_oe), 32'd0);
        check("R7 hiz core_en_a2b", 32'(core_en_a2b), 32'd0);
        check("R7 hiz core_en_b2a_n", 32'(core_en_b2a_n), 32'h3);
        mode = 2'b01;
        #1;
        check("R7 test core_a_in", 32'(core_a_in), 32'h9);
        check("R7 test core_b_in", 32'(core_b_in), 32'h6);
        check("R7 test core_en_a2b", 32'(core_en_a2b), 32'd0);
        check("R7 test core_en_b2a_n", 32'(core_en_b2a_n), 32'h3);

        // R4: normal mode follows the core, latches ignored
        for (int k = 0; k < 4; k++) begin
            mode = (k == 3) ? 2'b11 : 2'b00;
            core_a_out = W'(k * 3 + 1); core_b_out = W'(15 - k * 4);
            core_a_oe = k[1:0]; core_b_oe = ~k[1:0];
            a_pin_in = W'(k * 7); b_pin_in = W'(k + 8);
            en_a2b_pin = k[1:0]; en_b2a_n_pin = ~k[1:0];
            #1;
            check("R4 a_out", 32'(a_pin_out), 32'(core_a_out));
            check("R4 b_out", 32'(b_pin_out), 32'(core_b_out));
            check("R4 a_oe", 32'(a_pin_oe), 32'(core_a_oe));
            check("R4 b_oe", 32'(b_pin_oe), 32'(core_b_oe));
            check("R4 core_a_in", 32'(core_a_in), 32'(a_pin_in));
            check("R4 core_en", 32'({core_en_a2b, core_en_b2a_n}), 32'({en_a2b_pin, en_b2a_n_pin}));
            step();
        end

        // R2: serial order through the chain
        mode = 2'b00;
        v = N'(12'hA5C);
        load_vec(v, 1'b0);
        shift_dr = 1'b1; scan_in = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            check("R2 scan order", 32'(scan_out), 32'(v[i]));
            step();
        end
        shift_dr = 1'b0;

        // R9: normal-mode capture, per-group source
        for (int p = 0; p < 2; p++) begin
            mode = 2'b00;
            core_a_oe = p ? 2'b10 : 2'b01; core_b_oe = ~core_a_oe;
            core_a_out = 4'b1010; a_pin_in = 4'b0101;
            core_b_out = 4'b0011; b_pin_in = 4'b1100;
            en_a2b_pin = p ? 2'b01 : 2'b10; en_b2a_n_pin = ~en_a2b_pin;
            exp = '0;
            for (int i = 0; i < W; i++) begin
                exp[i]     = core_a_oe[i / GW] ? core_a_out[i] : a_pin_in[i];
                exp[W + i] = core_b_oe[i / GW] ? core_b_out[i] : b_pin_in[i];
            end
            for (int g = 0; g < NGRP; g++) begin
                exp[DIRB + 2*g]     = en_a2b_pin[g];
                exp[DIRB + 2*g + 1] = en_b2a_n_pin[g];
            end
            readout(got);
            check("R9 normal capture", 32'(got), 32'(exp));
        end

        // R10: test-mode capture takes the pins
        mode = 2'b01;
        exp = '0;
        exp[W-1:0] = a_pin_in; exp[DIRB-1:W] = b_pin_in;
        for (int g = 0; g < NGRP; g++) begin
            exp[DIRB + 2*g]     = en_a2b_pin[g];
            exp[DIRB + 2*g + 1] = en_b2a_n_pin[g];
        end
        readout(got);
        check("R10 test capture", 32'(got), 32'(exp));

        // R11: deselected strobes do nothing (chain is all zero after readout)
        bsr_sel = 1'b0; shift_dr = 1'b1; scan_in = 1'b1;
        repeat (N) step();
        shift_dr = 1'b0;
        check("R11 scan_out held", 32'(scan_out), 32'd0);
        update_dr = 1'b1; capture_dr = 1'b1;
        step();
        update_dr = 1'b0; capture_dr = 1'b0;
        check_test_pins("R11 latches held", cur_lat);
        check("R11 scan_out after capture", 32'(scan_out), 32'd0);
        bsr_sel = 1'b1; update_dr = 1'b1;
        step();
        update_dr = 1'b0;
        check_test_pins("R3 update loads chain", '0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule